// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up a translation in a hashed page table held in ordinary memory. A request gives it a virtual segment ID, an effective address and a load/store flag. The walker forms a hash from the segment ID and the page index, turns that hash into the address of a group of eight entries under a table base and a size mask, and reads the entries one after another. If no entry in that group matches, it repeats the scan in a second group chosen by the complemented hash. Each entry carries a bit that records which of the two hashes placed it.

On a match the walker marks the entry as referenced, and for a store also as changed. It writes the second entry word back to memory only when one of those bits was not already set. It returns both entry words, the real address and a flag that says whether a write may use the result. A load never gets that flag, so a later store to the same page has to walk again and set the changed bit. Memory is reached through a single request/acknowledge port that carries 32-bit reads and writes. The caller uses a start/busy/done handshake.

Top module: `hpt_walker`

## Requirements
- R1: While reset is high, and in the cycle after it, `busy`, `done` and `mem_req` are low.
- R2: The page index is `ea[27:12]`. The primary hash is the zero-extended `vsid` XOR the zero-extended page index. The secondary hash is its 32-bit complement. The group address is `tbl_base + ((hash << 6) & tbl_mask)`. Entry k sits at group + 8k, with its first word at +0 and its second word at +4.
- R3: First word of an entry: bit 31 is valid, bits 30:7 hold the segment ID, bit 6 selects the hash (0 primary, 1 secondary), and bits 5:0 hold page index bits 15:10. An entry matches only when it is valid, its hash-select bit equals the current pass, and both of its other fields are equal to the request.
- R4: Entries are read in order from 0 to 7, with two reads per entry (first word, then second word). The first matching entry is the one returned.
- R5: The secondary group is read only after all eight primary entries miss. If both groups miss, `hit` is 0 after 32 reads and `pte_w0`, `pte_w1`, `real_addr` and `writable` are zero.
- R6: On a hit, `pte_w1` is the second word read from memory with bit 8 (referenced) set. Bit 7 (changed) is also set when `store` was high.
- R7: The updated second word is written to its own address only if it differs from the word read. No other write occurs.
- R8: `writable` is 1 only on a hit for a store. A load hit reports 0.
- R9: `real_addr` is second-word bits 31:12 joined with `ea[11:0]`.
- R10: `start` is taken only while `busy` is low. Request inputs are captured at that point. `busy` stays high until `done`. `done` is a one-cycle pulse, and results are valid while it is high and stay until the next start. A `start` while busy is ignored.
- R11: A memory request, once raised, keeps its address, write enable and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| store | input | 1 | Access is a store |
| vsid | input | 24 | Virtual segment ID |
| ea | input | 32 | Effective address |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 32 | Group offset mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Matching entry found |
| pte_w0 | output | 32 | First word of the matching entry |
| pte_w1 | output | 32 | Second word with status bits updated |
| real_addr | output | 32 | Translated address |
| writable | output | 1 | Result may be used for a write |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of a 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |

## Verification
The bench places entries in the primary group that would match except that their hash-select bit is 1, or that their valid bit is 0. A walker that ignored either bit would return the wrong entry and read fewer words than expected. It also places two matching entries in one group: a walker that kept the last match would return the wrong real page number. It runs a walk that misses in both groups, where a walker without a second pass, or one that forgot the complement, would stop after 16 reads or read the wrong addresses. It repeats a load and then a store on an entry whose bits are already set: a walker that always wrote back would show extra writes, and one that left out the changed bit or granted writes to loads would return the wrong word or flag.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TAG,
    ST_RD_DATA,
    ST_WRBACK,
    ST_FIN
  } walk_st_e;

  localparam int TAG_VALID_BIT = 31;
  localparam int TAG_HSEL_BIT  = 6;
  localparam int DATA_REF_BIT  = 8;
  localparam int DATA_CHG_BIT  = 7;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int AW        = 32,
  parameter int VSID_W    = 24,
  parameter int PIDX_W    = 16,
  parameter int PG_SHIFT  = 12,
  parameter int GRP_SHIFT = 6,
  parameter int API_W     = 6,
  parameter int KEY_SHIFT = 7
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [AW-1:0]     ea,
  input  logic              pass,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     mask,
  output logic [AW-1:0]     grp_addr,
  output logic [AW-1:0]     key_word
);
  logic [PIDX_W-1:0] pidx;
  logic [AW-1:0]     h_pri;
  logic [AW-1:0]     h_sel;

  assign pidx     = ea[PG_SHIFT+PIDX_W-1:PG_SHIFT];
  assign h_pri    = AW'(vsid) ^ AW'(pidx);
  assign h_sel    = pass ? ~h_pri : h_pri;
  assign grp_addr = base + ((h_sel << GRP_SHIFT) & mask);
  assign key_word = (AW'(vsid) << KEY_SHIFT) | AW'(pidx[PIDX_W-1:PIDX_W-API_W]);
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int DW        = 32,
  parameter int VALID_BIT = 31,
  parameter int HSEL_BIT  = 6
) (
  input  logic [DW-1:0] tag,
  input  logic [DW-1:0] key_word,
  input  logic          pass,
  output logic          match
);
  localparam logic [DW-1:0] FLAG_BITS = (DW'(1) << VALID_BIT) | (DW'(1) << HSEL_BIT);
  localparam logic [DW-1:0] KEY_MASK  = ~FLAG_BITS;

  assign match = tag[VALID_BIT] && (tag[HSEL_BIT] == pass) &&
                 (((tag ^ key_word) & KEY_MASK) == '0);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int VSID_W      = 24,
  parameter int GROUP_N     = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int PG_SHIFT    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              store,
  input  logic [VSID_W-1:0] vsid,
  input  logic [AW-1:0]     ea,
  input  logic [AW-1:0]     tbl_base,
  input  logic [AW-1:0]     tbl_mask,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [DW-1:0]     pte_w0,
  output logic [DW-1:0]     pte_w1,
  output logic [AW-1:0]     real_addr,
  output logic              writable,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack
);
  localparam int IDX_W       = $clog2(GROUP_N);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int W1_OFF      = ENTRY_BYTES / 2;
  localparam int GRP_SHIFT   = $clog2(GROUP_N * ENTRY_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_N - 1);

  walk_st_e          st_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DW-1:0]     tag_q;
  logic [DW-1:0]     wdata_q;
  logic [AW-1:0]     ea_q;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     mask_q;
  logic [VSID_W-1:0] vsid_q;
  logic              store_q;

  logic [AW-1:0] grp_addr;
  logic [AW-1:0] key_word;
  logic          entry_match;
  logic [DW-1:0] upd_w1;

  hpt_hash #(
    .AW(AW), .VSID_W(VSID_W), .PG_SHIFT(PG_SHIFT), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid(vsid_q), .ea(ea_q), .pass(pass_q), .base(base_q), .mask(mask_q),
    .grp_addr(grp_addr), .key_word(key_word)
  );

  hpt_match #(
    .DW(DW), .VALID_BIT(TAG_VALID_BIT), .HSEL_BIT(TAG_HSEL_BIT)
  ) u_match (
    .tag(tag_q), .key_word(key_word), .pass(pass_q), .match(entry_match)
  );

  // referenced always, changed only for stores
  assign upd_w1 = mem_rdata | (DW'(1) << DATA_REF_BIT) |
                  (store_q ? (DW'(1) << DATA_CHG_BIT) : '0);

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign mem_req   = (st_q == ST_RD_TAG) || (st_q == ST_RD_DATA) || (st_q == ST_WRBACK);
  assign mem_we    = (st_q == ST_WRBACK);
  assign mem_wdata = wdata_q;
  assign mem_addr  = grp_addr + (AW'(idx_q) << ENTRY_SHIFT) +
                     ((st_q == ST_RD_TAG) ? '0 : AW'(W1_OFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pass_q    <= 1'b0;
      idx_q     <= '0;
      tag_q     <= '0;
      wdata_q   <= '0;
      ea_q      <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      vsid_q    <= '0;
      store_q   <= 1'b0;
      hit       <= 1'b0;
      pte_w0    <= '0;
      pte_w1    <= '0;
      real_addr <= '0;
      writable  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            ea_q      <= ea;
            vsid_q    <= vsid;
            store_q   <= store;
            base_q    <= tbl_base;
            mask_q    <= tbl_mask;
            pass_q    <= 1'b0;
            idx_q     <= '0;
            hit       <= 1'b0;
            pte_w0    <= '0;
            pte_w1    <= '0;
            real_addr <= '0;
            writable  <= 1'b0;
            st_q      <= ST_RD_TAG;
          end
        end
        ST_RD_TAG: begin
          if (mem_ack) begin
            tag_q <= mem_rdata;
            st_q  <= ST_RD_DATA;
          end
        end
        ST_RD_DATA: begin
          if (mem_ack) begin
            if (entry_match) begin
              hit       <= 1'b1;
              writable  <= store_q;
              pte_w0    <= tag_q;
              pte_w1    <= upd_w1;
              real_addr <= {mem_rdata[DW-1:PG_SHIFT], ea_q[PG_SHIFT-1:0]};
              wdata_q   <= upd_w1;
              st_q      <= (upd_w1 != mem_rdata) ? ST_WRBACK : ST_FIN;
            end else if (idx_q == LAST_IDX) begin
              idx_q <= '0;
              if (!pass_q) begin
                pass_q <= 1'b1;
                st_q   <= ST_RD_TAG;
              end else begin
                st_q <= ST_FIN;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_RD_TAG;
            end
          end
        end
        ST_WRBACK: begin
          if (mem_ack) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11: request held steady until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: done lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a walk only begins after a start request
  a_r10_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6: any write-back carries the referenced bit
  a_r6_wb_ref: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[DATA_REF_BIT]);

  // R8: write permission only accompanies a hit
  a_r8_wr_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (done && writable) |-> hit);
endmodule

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        store = 1'b0;
  logic [23:0] vsid = '0;
  logic [31:0] ea = '0;
  logic [31:0] tbl_base = 32'h0001_0000;
  logic [31:0] tbl_mask = 32'h0000_3FC0;
  logic        busy, done, hit, writable;
  logic [31:0] pte_w0, pte_w1, real_addr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst(rst), .start(start), .store(store), .vsid(vsid), .ea(ea),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(busy), .done(done), .hit(hit),
    .pte_w0(pte_w0), .pte_w1(pte_w1), .real_addr(real_addr), .writable(writable),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem [int unsigned];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_wa = '0;
  logic [31:0] last_wd = '0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory: acknowledges one cycle after seeing a request
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          mem_rdata <= peek(mem_addr);
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int tests = 0;
  int fails = 0;
  int clk_tests = 0;
  int clk_fails = 0;
  logic wd_fail = 1'b0;
  logic idle_chk = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the handshake and bus rules
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_req && !p_ack) begin
        clk_tests++;
        if (!(mem_req && mem_addr == p_addr && mem_we == p_we)) begin
          clk_fails++;
          $display("FAIL R11 act=%h exp=%h", mem_addr, p_addr);
        end
      end
      if (idle_chk) begin
        clk_tests++;
        if (busy || done || mem_req) begin
          clk_fails++;
          $display("FAIL R10 act=%h exp=%h", {busy, done, mem_req}, 3'b000);
        end
      end
    end
    p_req  = mem_req;
    p_ack  = mem_ack;
    p_we   = mem_we;
    p_addr = mem_addr;
  end

  // reference helpers
  function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] e, input logic sec);
    logic [31:0] h;
    h = {8'h0, v} ^ {16'h0, e[27:12]};
    if (sec) h = ~h;
    return tbl_base + ((h * 64) & tbl_mask);
  endfunction

  function automatic logic [31:0] tagw(input logic valid, input logic [23:0] v, input logic sec, input logic [31:0] e);
    return {valid, v, sec, e[27:22]};
  endfunction

  task automatic model(input logic [23:0] v, input logic [31:0] e, input logic st,
                       output logic ehit, output logic [31:0] ew0, output logic [31:0] ew1,
                       output logic [31:0] era, output int erd, output int ewr,
                       output logic [31:0] ewa);
    ehit = 0; ew0 = 0; ew1 = 0; era = 0; erd = 0; ewr = 0; ewa = 0;
    for (int p = 0; p < 2 && !ehit; p++) begin
      for (int k = 0; k < 8 && !ehit; k++) begin
        logic [31:0] a, t, d;
        a = grp(v, e, p[0]) + 32'(k * 8);
        t = peek(a);
        d = peek(a + 4);
        erd += 2;
        if (t[31] && t[6] == p[0] && t[30:7] == v && t[5:0] == e[27:22]) begin
          ehit = 1;
          ew0 = t;
          ew1 = d | 32'h100 | (st ? 32'h80 : 32'h0);
          era = {d[31:12], e[11:0]};
          if (ew1 != d) begin
            ewr = 1;
            ewa = a + 4;
          end
        end
      end
    end
  endtask

  task automatic walk(input string nm, input logic [23:0] v, input logic [31:0] e,
                      input logic st, input logic poke);
    logic ehit; logic [31:0] ew0, ew1, era, ewa; int erd, ewr;
    int r0, w0, n;
    model(v, e, st, ehit, ew0, ew1, era, erd, ewr, ewa);
    idle_chk = 1'b0;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    vsid = v; ea = e; store = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; vsid = ~v; ea = ~e; store = ~st;
      @(negedge clk);
      start = 1'b0; vsid = v; ea = e; store = st;
    end
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, {nm, " R10 done"}, 32'(done), 1);
    chk(hit === ehit, {nm, (ehit ? " R4 hit" : " R5 miss")}, 32'(hit), 32'(ehit));
    chk(pte_w0 === ew0, {nm, " R3 pte_w0"}, pte_w0, ew0);
    chk(pte_w1 === ew1, {nm, " R6 pte_w1"}, pte_w1, ew1);
    chk(real_addr === era, {nm, " R9 real_addr"}, real_addr, era);
    chk(writable === (ehit && st), {nm, " R8 writable"}, 32'(writable), 32'(ehit && st));
    chk(rd_cnt - r0 == erd, {nm, " R4 read count"}, 32'(rd_cnt - r0), 32'(erd));
    chk(wr_cnt - w0 == ewr, {nm, " R7 write count"}, 32'(wr_cnt - w0), 32'(ewr));
    if (ewr == 1) begin
      chk(last_wa === ewa, {nm, " R7 write addr"}, last_wa, ewa);
      chk(last_wd === ew1, {nm, " R7 write data"}, last_wd, ew1);
    end
    @(negedge clk);
    chk(!done && !busy, {nm, " R10 pulse"}, {30'h0, done, busy}, 0);
    idle_chk = 1'b1;
  endtask

  localparam logic [23:0] VA = 24'h001234;
  localparam logic [31:0] EA_A = 32'h1234_5678;
  localparam logic [23:0] VB = 24'h0ABCDE;
  localparam logic [31:0] EA_B = 32'h0765_4321;
  localparam logic [23:0] VC = 24'h055555;
  localparam logic [31:0] EA_C = 32'h0000_1000;
  localparam logic [23:0] VD = 24'h000F0F;
  localparam logic [31:0] EA_D = 32'h0FED_C000;
  localparam logic [23:0] VE = 24'h333333;
  localparam logic [31:0] EA_E = 32'h0111_2FFF;

  initial begin
    logic [31:0] g;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset", {29'h0, busy, done, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 after reset", {29'h0, busy, done, mem_req}, 0);
    idle_chk = 1'b1;

    // R2 R4: primary hit in slot 0; load, repeat load, store, repeat store
    g = grp(VA, EA_A, 0);
    mem[g] = tagw(1, VA, 0, EA_A);
    mem[g + 4] = 32'hABCDE000;
    walk("A load", VA, EA_A, 0, 0);
    chk(peek(g + 4) === 32'hABCDE100, "R7 stored word after load", peek(g + 4), 32'hABCDE100);
    walk("A load again", VA, EA_A, 0, 0);
    walk("A store", VA, EA_A, 1, 0);
    chk(peek(g + 4) === 32'hABCDE180, "R6 stored word after store", peek(g + 4), 32'hABCDE180);
    walk("A store again", VA, EA_A, 1, 0);

    // R3 R5: primary decoys (wrong hash bit, invalid, other segment), secondary hit in slot 3
    mem.delete();
    g = grp(VB, EA_B, 0);
    mem[g] = tagw(1, VB, 1, EA_B);  mem[g + 4] = 32'h11111000;
    mem[g + 8] = tagw(0, VB, 0, EA_B); mem[g + 12] = 32'h22222000;
    for (int k = 2; k < 8; k++) mem[g + 32'(k * 8)] = tagw(1, VB ^ 24'h1, 0, EA_B);
    g = grp(VB, EA_B, 1);
    for (int k = 0; k < 3; k++) mem[g + 32'(k * 8)] = tagw(1, VB, 0, EA_B);
    mem[g + 24] = tagw(1, VB, 1, EA_B); mem[g + 28] = 32'h5A5A5000;
    walk("B secondary", VB, EA_B, 0, 0);

    // R5 R10: miss in both groups, with an extra start while busy
    mem.delete();
    walk("C miss", VC, EA_C, 1, 1);

    // R4 R6: last slot of primary, referenced already set, store sets only changed
    mem.delete();
    g = grp(VD, EA_D, 0);
    mem[g + 56] = tagw(1, VD, 0, EA_D); mem[g + 60] = 32'h0F0F0100;
    walk("D slot7 store", VD, EA_D, 1, 0);

    // R4: first of two matches wins
    mem.delete();
    g = grp(VE, EA_E, 0);
    mem[g + 16] = tagw(1, VE, 0, EA_E); mem[g + 20] = 32'hAAAAA180;
    mem[g + 40] = tagw(1, VE, 0, EA_E); mem[g + 44] = 32'hBBBBB000;
    walk("E first match", VE, EA_E, 0, 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests + clk_tests, fails + clk_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + clk_tests + 1, fails + clk_fails + 1);
    $finish;
  end
endmodule